// File: doc/BRIEF.md
# Associative Bit-Serial SIMD Array

This block is a row of identical processing elements that all obey one instruction stream broadcast by a controller. Each element holds a data word, a one-bit activity tag and a one-bit carry. The controller sends an operation code with a scalar key, a bit mask and the field positions. Elements are chosen by what they contain, not by their index: a match operation tags every element whose masked bits equal the masked key. Later write, read and add operations act only on the tagged elements.

Arithmetic is bit-serial. An add over a field of L bits takes L cycles, one bit per cycle from the least significant bit upward, and a busy flag stays high for that time. A field is any run of adjacent bits inside the word, given by a start bit and a length. The addend is either the low bits of the broadcast key or a second field of the same word. A some-or-none flag reports to the controller whether any element is tagged. A read returns the masked word of the lowest-indexed tagged element. The words are filled through a serial load port that shifts data along the row.

Top module: `assoc_simd_array`

## Requirements
- R1: After a synchronous active-low reset, every word is zero, every tag is clear, and busy, any_match, rd_valid and rd_data are all zero.
- R2: When load_en is high while busy and cmd_valid are low, load_data enters element 0 and every element i>0 takes the old word of element i-1. After NUM_PE loads, the k-th loaded word (k counted from 0) is in element NUM_PE-1-k.
- R3: MATCH (cmd_op 3'd1) sets each element's tag to ((word ^ cmd_key) & cmd_mask) == 0 and clears it otherwise. In the cycle after the command, any_match is 1 exactly when at least one tag is set.
- R4: WRITE (cmd_op 3'd2) sets word = (word & ~cmd_mask) | (cmd_key & cmd_mask) in every tagged element. Untagged elements keep their words.
- R5: READ (cmd_op 3'd3) sets rd_valid=1 and rd_data = word & cmd_mask of the lowest-indexed tagged element in the next cycle. If no element is tagged, it sets rd_valid=0 and rd_data=0. Both outputs hold until the next READ.
- R6: ADD_KEY (cmd_op 3'd4) replaces the field of cmd_len bits starting at cmd_dst_lsb in every tagged element with (field + cmd_key[cmd_len-1:0]) mod 2^cmd_len. All other bits and all untagged elements are unchanged.
- R7: ADD_FIELD (cmd_op 3'd5) replaces the destination field with (destination + source) mod 2^cmd_len in every tagged element. The source field is the cmd_len bits starting at cmd_src_lsb of the same word and stays unchanged. Source and destination must not overlap.
- R8: After an add with cmd_len >= 1 is accepted, busy is high for exactly cmd_len cycles, and the result is complete when busy falls.
- R9: Each element's carry is cleared at the start of every add, so a carry out of one add never reaches the next add.
- R10: While busy is high, commands and loads are ignored, and the tags do not change. An add with cmd_len = 0 changes nothing and leaves busy low. Fields must satisfy lsb + len <= WORD_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Shift load_data into the row |
| load_data | input | WORD_W | Word entering element 0 |
| cmd_valid | input | 1 | Broadcast command present |
| cmd_op | input | 3 | Operation code |
| cmd_key | input | WORD_W | Scalar key, write value or addend |
| cmd_mask | input | WORD_W | Bit mask for match, write and read |
| cmd_src_lsb | input | $clog2(WORD_W) | Start bit of the source field |
| cmd_dst_lsb | input | $clog2(WORD_W) | Start bit of the destination field |
| cmd_len | input | $clog2(WORD_W)+1 | Field length for adds |
| busy | output | 1 | Bit-serial add in progress |
| any_match | output | 1 | At least one element tagged |
| rd_valid | output | 1 | Last read found a tagged element |
| rd_data | output | WORD_W | Masked word of the lowest tagged element |

## Verification
Every element carries a unique identity nibble in its top bits. After each operation, the bench reads back all sixteen words by matching on that nibble, so any element touched by mistake, or any bit outside a field that changes, is seen. The bench varies the tag patterns: all elements tagged, odd-indexed elements only, a single element, and none. These patterns separate content gating from index gating, and they check the lowest-index priority of the read. Adds sweep field lengths 1 to 12 at varied start bits, with both key and field addends. Keys are chosen to overflow, and an overflowing add is followed at once by an add of zero, which exposes carry leakage and off-by-one bit counts. The bench also issues a command and a load while busy, and an add of length zero, to show that they are ignored.

// File: rtl/asp_pkg.sv
// Package: shared operation codes for the associative array.
// Assumes: a 3-bit opcode field on the command port.
package asp_pkg;
    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_MATCH     = 3'd1,
        OP_WRITE     = 3'd2,
        OP_READ      = 3'd3,
        OP_ADD_KEY   = 3'd4,
        OP_ADD_FIELD = 3'd5
    } asp_op_e;
endpackage

// File: rtl/asp_seq.sv
// Module: asp_seq - bit-serial add sequencer.
// Accepts an add when idle, then steps one bit position per cycle for
// len cycles, broadcasting the bit positions, the key bit and a first-step
// flag that clears the element carries. Assumes lsb + len <= WORD_W.
module asp_seq
    import asp_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int POS_W = $clog2(WORD_W),
    localparam int LEN_W = POS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [WORD_W-1:0] cmd_key,
    input  logic [POS_W-1:0] cmd_src_lsb,
    input  logic [POS_W-1:0] cmd_dst_lsb,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             busy,
    output logic             first,
    output logic [POS_W-1:0] dst_pos,
    output logic [POS_W-1:0] src_pos,
    output logic             key_bit,
    output logic             use_field
);
    logic              busy_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  len_q;
    logic [POS_W-1:0]  dst_q;
    logic [POS_W-1:0]  src_q;
    logic [WORD_W-1:0] key_q;
    logic              field_q;
    logic              is_add;

    // Decode whether the incoming command starts a serial add.
    assign is_add = (asp_op_e'(cmd_op) == OP_ADD_KEY) || (asp_op_e'(cmd_op) == OP_ADD_FIELD);

    // Start, advance and finish the serial add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            len_q   <= '0;
            dst_q   <= '0;
            src_q   <= '0;
            key_q   <= '0;
            field_q <= 1'b0;
        end else if (!busy_q) begin
            if (cmd_valid && is_add && (cmd_len != '0)) begin
                busy_q  <= 1'b1;
                cnt_q   <= '0;
                len_q   <= cmd_len;
                dst_q   <= cmd_dst_lsb;
                src_q   <= cmd_src_lsb;
                key_q   <= cmd_key;
                field_q <= (asp_op_e'(cmd_op) == OP_ADD_FIELD);
            end
        end else begin
            cnt_q <= cnt_q + LEN_W'(1);
            if (cnt_q == len_q - LEN_W'(1)) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Broadcast the current bit positions and operand bit.
    assign busy      = busy_q;
    assign first     = (cnt_q == '0);
    assign dst_pos   = dst_q + cnt_q[POS_W-1:0];
    assign src_pos   = src_q + cnt_q[POS_W-1:0];
    assign key_bit   = key_q[cnt_q[POS_W-1:0]];
    assign use_field = field_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < len_q)); // R8
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (cnt_q == len_q - LEN_W'(1))) |=> !busy_q); // R8
    AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && cmd_valid && (cmd_len == '0)) |=> !busy_q); // R10
endmodule

// File: rtl/asp_pe.sv
// Module: asp_pe - one associative processing element.
// Holds a data word, a match tag and a serial-add carry. Every command is
// gated by the tag as it stood before the command. Assumes the controller
// never asserts match_en, write_en and step together.
module asp_pe #(
    parameter int WORD_W = 32,
    localparam int POS_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] shift_in,
    input  logic              match_en,
    input  logic              write_en,
    input  logic [WORD_W-1:0] key,
    input  logic [WORD_W-1:0] mask,
    input  logic              step,
    input  logic              first,
    input  logic [POS_W-1:0]  dst_pos,
    input  logic [POS_W-1:0]  src_pos,
    input  logic              key_bit,
    input  logic              use_field,
    output logic [WORD_W-1:0] word,
    output logic              tag
);
    logic [WORD_W-1:0] word_q;
    logic              tag_q;
    logic              carry_q;
    logic              a_bit, b_bit, c_in, sum_bit, c_out;

    // Form one full-adder step on the current bit position.
    always_comb begin
        a_bit   = word_q[dst_pos];
        b_bit   = use_field ? word_q[src_pos] : key_bit;
        c_in    = first ? 1'b0 : carry_q;
        sum_bit = a_bit ^ b_bit ^ c_in;
        c_out   = (a_bit & b_bit) | (a_bit & c_in) | (b_bit & c_in);
    end

    // Update the tag on a match command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= 1'b0;
        end else if (match_en) begin
            tag_q <= (((word_q ^ key) & mask) == '0);
        end
    end

    // Update the word from the load chain, a masked write or an add step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= shift_in;
        end else if (write_en && tag_q) begin
            word_q <= (word_q & ~mask) | (key & mask);
        end else if (step && tag_q) begin
            word_q[dst_pos] <= sum_bit;
        end
    end

    // Keep the carry between serial add steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (step && tag_q) begin
            carry_q <= c_out;
        end
    end

    assign word = word_q;
    assign tag  = tag_q;

    AST_UNTAGGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tag_q && !shift_en) |=> $stable(word_q)); // R4
    AST_TAG_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(tag_q)); // R10
endmodule

// File: rtl/asp_first_sel.sv
// Module: asp_first_sel - lowest-index tag selector.
// Finds the lowest-numbered set tag and reports whether any tag is set.
// Assumes NUM_PE >= 2.
module asp_first_sel #(
    parameter int NUM_PE = 16,
    localparam int IDX_W = $clog2(NUM_PE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PE-1:0] tags,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    // Scan from the top so the lowest set tag wins last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_PE - 1; i >= 0; i--) begin
            if (tags[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    AST_SEL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (tags[idx] && ((tags & ((NUM_PE'(1) << idx) - NUM_PE'(1))) == '0))); // R5
    AST_SEL_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (tags == '0)); // R3
endmodule

// File: rtl/assoc_simd_array.sv
// Module: assoc_simd_array - top of the associative bit-serial SIMD row.
// Broadcasts each command to NUM_PE elements, chains them for serial
// loading, and registers the read of the lowest tagged element.
// Assumes commands are held off by the caller while busy is high.
module assoc_simd_array
    import asp_pkg::*;
#(
    parameter int NUM_PE = 16,
    parameter int WORD_W = 32,
    localparam int POS_W = $clog2(WORD_W),
    localparam int LEN_W = POS_W + 1,
    localparam int IDX_W = $clog2(NUM_PE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_data,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_key,
    input  logic [WORD_W-1:0] cmd_mask,
    input  logic [POS_W-1:0]  cmd_src_lsb,
    input  logic [POS_W-1:0]  cmd_dst_lsb,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              any_match,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    logic              accept, match_en, write_en, read_en, shift_en;
    logic              s_first, s_key_bit, s_use_field;
    logic [POS_W-1:0]  s_dst_pos, s_src_pos;
    logic [WORD_W-1:0] words    [NUM_PE];
    logic [WORD_W-1:0] chain_in [NUM_PE];
    logic [NUM_PE-1:0] tags;
    logic              sel_found;
    logic [IDX_W-1:0]  sel_idx;
    logic              rd_valid_q;
    logic [WORD_W-1:0] rd_data_q;

    // Decode the accepted command into per-operation enables.
    assign accept   = cmd_valid && !busy;
    assign match_en = accept && (asp_op_e'(cmd_op) == OP_MATCH);
    assign write_en = accept && (asp_op_e'(cmd_op) == OP_WRITE);
    assign read_en  = accept && (asp_op_e'(cmd_op) == OP_READ);
    assign shift_en = load_en && !busy && !cmd_valid;

    asp_seq #(.WORD_W(WORD_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_key    (cmd_key),
        .cmd_src_lsb(cmd_src_lsb),
        .cmd_dst_lsb(cmd_dst_lsb),
        .cmd_len    (cmd_len),
        .busy       (busy),
        .first      (s_first),
        .dst_pos    (s_dst_pos),
        .src_pos    (s_src_pos),
        .key_bit    (s_key_bit),
        .use_field  (s_use_field)
    );

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        if (g == 0) begin : g_head
            assign chain_in[g] = load_data;
        end else begin : g_link
            assign chain_in[g] = words[g-1];
        end
        asp_pe #(.WORD_W(WORD_W)) u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .shift_in (chain_in[g]),
            .match_en (match_en),
            .write_en (write_en),
            .key      (cmd_key),
            .mask     (cmd_mask),
            .step     (busy),
            .first    (s_first),
            .dst_pos  (s_dst_pos),
            .src_pos  (s_src_pos),
            .key_bit  (s_key_bit),
            .use_field(s_use_field),
            .word     (words[g]),
            .tag      (tags[g])
        );
    end

    asp_first_sel #(.NUM_PE(NUM_PE)) u_sel (
        .clk  (clk),
        .rst_n(rst_n),
        .tags (tags),
        .found(sel_found),
        .idx  (sel_idx)
    );

    // Capture the masked word of the lowest tagged element on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else if (read_en) begin
            rd_valid_q <= sel_found;
            rd_data_q  <= sel_found ? (words[sel_idx] & cmd_mask) : '0;
        end
    end

    assign any_match = |tags;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;

    AST_READ_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (read_en && !any_match) |=> (!rd_valid && (rd_data == '0))); // R5
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !read_en |=> ($stable(rd_valid) && $stable(rd_data))); // R5
    AST_MATCH_IDLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tags)); // R10
endmodule

// File: tb/assoc_simd_array_tb.sv
`timescale 1ns/1ps
module assoc_simd_array_tb;
    localparam int N = 16;
    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] load_data = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_key = '0;
    logic [31:0] cmd_mask = '0;
    logic [4:0]  cmd_src_lsb = '0;
    logic [4:0]  cmd_dst_lsb = '0;
    logic [5:0]  cmd_len = '0;
    logic        busy, any_match, rd_valid;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [31:0] m [N];
    bit          tg [N];

    assoc_simd_array #(.NUM_PE(N), .WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_mask(cmd_mask),
        .cmd_src_lsb(cmd_src_lsb), .cmd_dst_lsb(cmd_dst_lsb), .cmd_len(cmd_len),
        .busy(busy), .any_match(any_match), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fld(input logic [31:0] w, input int lsb, input int len);
        longint fm = (64'd1 << len) - 1;
        return 32'((longint'(w) >> lsb) & fm);
    endfunction

    function automatic logic [31:0] put(input logic [31:0] w, input int lsb, input int len,
                                        input logic [31:0] v);
        longint fm = (64'd1 << len) - 1;
        longint r = longint'(w) & ~(fm << lsb);
        return 32'(r | ((longint'(v) & fm) << lsb));
    endfunction

    // Issue one command, update the model and check its visible outcome.
    task automatic do_cmd(input logic [2:0] op, input logic [31:0] key, input logic [31:0] mask,
                          input int src, input int dst, input int len, input string req);
        bit          ev = 0;
        logic [31:0] ed = '0;
        bit          ea = 0;
        int          nb = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_key = key; cmd_mask = mask;
        cmd_src_lsb = 5'(src); cmd_dst_lsb = 5'(dst); cmd_len = 6'(len);
        case (op)
            3'd1: for (int i = 0; i < N; i++) begin
                      tg[i] = (((m[i] ^ key) & mask) == 0);
                      if (tg[i]) ea = 1;
                  end
            3'd2: for (int i = 0; i < N; i++)
                      if (tg[i]) m[i] = (m[i] & ~mask) | (key & mask);
            3'd3: for (int i = N - 1; i >= 0; i--)
                      if (tg[i]) begin ev = 1; ed = m[i] & mask; end
            3'd4: if (len != 0) for (int i = 0; i < N; i++)
                      if (tg[i]) m[i] = put(m[i], dst, len, fld(m[i], dst, len) + key);
            3'd5: if (len != 0) for (int i = 0; i < N; i++)
                      if (tg[i]) m[i] = put(m[i], dst, len, fld(m[i], dst, len) + fld(m[i], src, len));
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == 3'd1) chk({req, " any_match"}, 32'(any_match), 32'(ea));
        if (op == 3'd3) begin
            chk({req, " rd_valid"}, 32'(rd_valid), 32'(ev));
            chk({req, " rd_data"}, rd_data, ed);
        end
        if (op == 3'd4 || op == 3'd5) begin
            while (busy) begin nb++; @(negedge clk); end
            chk({req, " R8 busy cycles"}, 32'(nb), 32'(len));
        end
    endtask

    // Read back every element through its identity nibble.
    task automatic dump(input string req);
        for (int i = 0; i < N; i++) begin
            do_cmd(3'd1, 32'(i) << 28, 32'hF000_0000, 0, 0, 0, "R3");
            do_cmd(3'd3, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, req);
        end
    endtask

    task automatic load_word(input logic [31:0] w);
        @(negedge clk);
        load_en = 1'b1; load_data = w;
        for (int j = N - 1; j > 0; j--) m[j] = m[j-1];
        m[0] = w;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m[i] = '0; tg[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs
        chk("R1 busy", 32'(busy), 0);
        chk("R1 any_match", 32'(any_match), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 rd_data", rd_data, 0);
        // R1: all words zero, so a full-mask match on zero tags every element
        do_cmd(3'd1, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, "R1 words zero");
        do_cmd(3'd3, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, "R1 read zero");

        // R2: serial load, k-th word lands in element N-1-k
        for (int k = 0; k < N; k++)
            load_word({4'(N - 1 - k), 28'(32'(k) * 32'h0123_4567 ^ 32'h05A5_A5A5)});
        dump("R2 load order");

        // R5: priority among odd-valued elements
        do_cmd(3'd1, 32'h1, 32'h1, 0, 0, 0, "R3 odd");
        do_cmd(3'd3, 32'h0, 32'h0FFF_FFFF, 0, 0, 0, "R5 lowest");
        // R5: nothing tagged
        do_cmd(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R3 none");
        do_cmd(3'd3, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, "R5 none");

        // R4: masked write on a content-selected subset
        do_cmd(3'd1, 32'h2, 32'h2, 0, 0, 0, "R3 bit1");
        do_cmd(3'd2, 32'h00AB_CD00, 32'h00FF_FF00, 0, 0, 0, "R4");
        dump("R4 write");

        // R6 and R9: overflowing add, then add zero must not see the carry
        do_cmd(3'd1, 32'h0, 32'h0, 0, 0, 0, "R3 all");
        do_cmd(3'd4, 32'hF, 32'h0, 0, 4, 4, "R6");
        do_cmd(3'd4, 32'h0, 32'h0, 0, 4, 4, "R9");
        dump("R9 carry clear");

        // R10: command and load during busy are ignored
        do_cmd(3'd1, 32'h0, 32'h0, 0, 0, 0, "R3 all");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_key = 32'h155; cmd_mask = '0;
        cmd_dst_lsb = 5'd2; cmd_src_lsb = 5'd0; cmd_len = 6'd10;
        for (int i = 0; i < N; i++) m[i] = put(m[i], 2, 10, fld(m[i], 2, 10) + 32'h155);
        @(negedge clk);
        cmd_op = 3'd2; cmd_key = 32'h0FFF_FFFF; cmd_mask = 32'h0FFF_FFFF;
        load_en = 1'b1; load_data = 32'hDEAD_BEEF;
        @(negedge clk);
        cmd_valid = 1'b0; load_en = 1'b0;
        while (busy) @(negedge clk);
        dump("R10 busy ignore");
        // R10: zero-length add
        do_cmd(3'd4, 32'hFF, 32'h0, 0, 3, 0, "R10 len0");
        dump("R10 len0");

        // R6/R7 sweep over lengths, start bits and tag sets
        for (int len = 1; len <= 12; len++) begin
            int lsb = (len * 5) % 16;
            do_cmd(3'd1, 32'(len & 1) << (len % 4), 32'h1 << (len % 4), 0, 0, 0, "R3 sweep");
            if (lsb + 2 * len <= 28 && (len % 2 == 0))
                do_cmd(3'd5, 32'h0, 32'h0, lsb + len, lsb, len, "R7");
            else
                do_cmd(3'd4, 32'hFFFF_FFFF - 32'(len * 3), 32'h0, 0, lsb, len, "R6");
            dump((len % 2 == 0) ? "R7 sweep" : "R6 sweep");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule